// File: doc/BRIEF.md
# Out-of-Order Issue Window with Tag Wakeup and Oldest-First Select

This block holds renamed instructions between decode and execution in a small window that is kept apart from the reorder buffer and may be shallower than it. Decode writes an instruction into a free slot. The slot holds the opcode, up to `NSRC` source tags with a "used" bit and a "ready" bit for each, a destination tag and the reorder-buffer index. Writeback lanes broadcast completed destination tags. Each broadcast marks as ready every waiting source whose tag matches. An instruction can be issued once all of its used sources are ready. A source that is not used counts as ready.

When several instructions are ready, an age matrix chooses the one that entered the window first, whatever slot it sits in. The window presents at most one instruction per cycle. The slot is released when execution accepts that instruction. A flush empties the window in one cycle.

Both data paths use valid/ready handshakes. The insert side accepts a beat when `ins_valid` and `ins_ready` are both high. `ins_ready` falls, and `win_full` rises, while every slot is occupied, so decode stalls. The issue side offers a beat with `iss_valid`. Once `iss_valid` is high and `iss_ready` is low, the window keeps presenting the same instruction with the same fields until the consumer accepts it or a flush arrives. `flush` is a plain control pin.

Top module: `iw_window`

## Requirements
- R1: After reset, `iss_valid` is 0, `win_full` is 0 and `ins_ready` is 1.
- R2: An insert beat is taken only when `ins_valid` and `ins_ready` are both high. Once `DEPTH` instructions are held, `win_full` is 1 and `ins_ready` is 0, and an insert offered while full is dropped and never issues. Releasing one slot clears `win_full`.
- R3: An instruction whose used sources are all flagged ready at insertion, with unused sources (used bit 0) treated as ready whatever their tag or ready flag, is offered on `iss_valid` in the cycle after insertion.
- R4: A `wb_valid[w]` pulse with `wb_tag[w]` equal to a waiting source's tag marks that source ready. The instruction is offered in the cycle after the broadcast that supplies its last missing source. Lane w occupies bits `[w*TAG_W +: TAG_W]` of `wb_tag`, and source s occupies bits `[s*TAG_W +: TAG_W]` of the source tag buses.
- R5: A broadcast in the same cycle as an insertion wakes the matching sources of the instruction being inserted.
- R6: A broadcast whose tag matches no waiting source has no effect, and neither does a tag on a lane whose `wb_valid` bit is 0.
- R7: When more than one instruction is ready, the one inserted earliest is offered first, regardless of slot position.
- R8: The issue beat carries exactly the opcode, source tags, destination tag and reorder-buffer index given at insertion.
- R9: While `iss_valid` is 1 and `iss_ready` is 0, the offered instruction stays unchanged, even if an older instruction becomes ready. A beat accepted with `iss_ready` = 1 frees its slot, and that instruction is not offered again.
- R10: `flush` empties the window by the next cycle, and an insert offered in the same cycle as the flush is dropped. The window accepts new inserts afterwards.
- R11: At most one instruction is offered per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the window |
| ins_valid | input | 1 | Insert beat offered |
| ins_ready | output | 1 | Window can take an insert |
| win_full | output | 1 | All slots occupied |
| ins_op | input | OP_W | Opcode to insert |
| ins_src_tag | input | NSRC*TAG_W | Source tags, source s at [s*TAG_W +: TAG_W] |
| ins_src_used | input | NSRC | Source s is used |
| ins_src_rdy | input | NSRC | Source s already ready at insertion |
| ins_dst_tag | input | TAG_W | Destination tag |
| ins_rob | input | ROB_W | Reorder-buffer index |
| wb_valid | input | NWB | Broadcast lane valid |
| wb_tag | input | NWB*TAG_W | Broadcast tags, lane w at [w*TAG_W +: TAG_W] |
| iss_valid | output | 1 | Issue beat offered |
| iss_ready | input | 1 | Execution accepts the beat |
| iss_op | output | OP_W | Issued opcode |
| iss_src_tag | output | NSRC*TAG_W | Issued source tags |
| iss_dst_tag | output | TAG_W | Issued destination tag |
| iss_rob | output | ROB_W | Issued reorder-buffer index |

## Verification
The hardest case to reach from the ports is an ordering conflict in which slot position and age disagree. A younger instruction must sit in a lower-numbered slot than an older ready one. While one instruction is stalled on the issue port, a still older one must wake up. The stimulus first fills the window with instructions that are all waiting. It then wakes and drains the one in slot 1 and refills that slot with a ready instruction. In the same cycle it wakes the entry in slot 3. With `iss_ready` held low, it then wakes the oldest entry. Only a correct age matrix together with the stall hold gives the expected order of reorder-buffer indices.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int DEF_DEPTH = 4;
  localparam int DEF_NSRC  = 2;
  localparam int DEF_NWB   = 2;
  localparam int DEF_TAG_W = 6;
  localparam int DEF_OP_W  = 7;
  localparam int DEF_ROB_W = 4;
endpackage

// File: rtl/iw_entry.sv
module iw_entry #(
  parameter int NSRC  = iw_pkg::DEF_NSRC,
  parameter int NWB   = iw_pkg::DEF_NWB,
  parameter int TAG_W = iw_pkg::DEF_TAG_W,
  parameter int OP_W  = iw_pkg::DEF_OP_W,
  parameter int ROB_W = iw_pkg::DEF_ROB_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   we,
  input  logic                   clr,
  input  logic [OP_W-1:0]        in_op,
  input  logic [NSRC*TAG_W-1:0]  in_src,
  input  logic [NSRC-1:0]        in_used,
  input  logic [NSRC-1:0]        in_rdy,
  input  logic [TAG_W-1:0]       in_dst,
  input  logic [ROB_W-1:0]       in_rob,
  input  logic [NWB-1:0]         wb_valid,
  input  logic [NWB*TAG_W-1:0]   wb_tag,
  output logic                   vld,
  output logic                   rdy,
  output logic [OP_W-1:0]        op,
  output logic [NSRC*TAG_W-1:0]  src,
  output logic [TAG_W-1:0]       dst,
  output logic [ROB_W-1:0]       rob
);
  logic [NSRC-1:0] src_rdy_q;
  logic [NSRC-1:0] hit_held;
  logic [NSRC-1:0] hit_new;

  // tag comparators: one per source per broadcast lane
  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      always_comb begin
        hit_held[s] = 1'b0;
        hit_new[s]  = 1'b0;
        for (int w = 0; w < NWB; w++) begin
          if (wb_valid[w] && wb_tag[w*TAG_W +: TAG_W] == src[s*TAG_W +: TAG_W])
            hit_held[s] = 1'b1;
          if (wb_valid[w] && wb_tag[w*TAG_W +: TAG_W] == in_src[s*TAG_W +: TAG_W])
            hit_new[s] = 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= 1'b0;
      src_rdy_q <= '0;
    end else begin
      if (flush)      vld <= 1'b0;
      else if (we)    vld <= 1'b1;
      else if (clr)   vld <= 1'b0;
      if (we) src_rdy_q <= ~in_used | in_rdy | hit_new;
      else    src_rdy_q <= src_rdy_q | hit_held;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op  <= '0;
      src <= '0;
      dst <= '0;
      rob <= '0;
    end else if (we) begin
      op  <= in_op;
      src <= in_src;
      dst <= in_dst;
      rob <= in_rob;
    end
  end

  assign rdy = vld & (&src_rdy_q);

  // allocator must only target a free slot (R2)
  assert_fill_free_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !vld);
  // an accepted issue releases the slot (R9)
  assert_release_after_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !we) |=> !vld);
endmodule

// File: rtl/iw_alloc.sv
module iw_alloc #(
  parameter int DEPTH = iw_pkg::DEF_DEPTH
) (
  input  logic [DEPTH-1:0] occ,
  output logic [DEPTH-1:0] slot_oh,
  output logic             full
);
  always_comb begin
    slot_oh = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (!occ[i]) slot_oh = DEPTH'(1) << i;
    end
  end
  assign full = &occ;
endmodule

// File: rtl/iw_age.sv
module iw_age #(
  parameter int DEPTH = iw_pkg::DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [DEPTH-1:0] ins_we,
  input  logic [DEPTH-1:0] rdy,
  input  logic             iss_ready,
  output logic [DEPTH-1:0] grant
);
  // older_q[i][j] = 1 : slot i entered before slot j
  logic [DEPTH-1:0][DEPTH-1:0] older_q;
  logic [DEPTH-1:0]            pick;
  logic [DEPTH-1:0]            held_q;
  logic                        hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        for (int j = 0; j < DEPTH; j++) begin
          if (ins_we[i])                older_q[i][j] <= 1'b0;
          else if (ins_we[j] && i != j) older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  // a ready slot wins unless some other ready slot is older
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_pick
      always_comb begin
        logic blocked;
        blocked = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
          if (rdy[j] && older_q[j][i]) blocked = 1'b1;
        end
        pick[i] = rdy[i] & ~blocked;
      end
    end
  endgenerate

  assign grant = hold_q ? held_q : pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      held_q <= '0;
    end else begin
      hold_q <= !flush && (|grant) && !iss_ready;
      held_q <= grant;
    end
  end

  assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_is_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~rdy) == '0);
  assert_grant_held_R9: assert property (@(posedge clk) disable iff (!rst_n || flush)
    ((|grant) && !iss_ready) |=> $stable(grant));
endmodule

// File: rtl/iw_window.sv
module iw_window #(
  parameter int DEPTH = iw_pkg::DEF_DEPTH,
  parameter int NSRC  = iw_pkg::DEF_NSRC,
  parameter int NWB   = iw_pkg::DEF_NWB,
  parameter int TAG_W = iw_pkg::DEF_TAG_W,
  parameter int OP_W  = iw_pkg::DEF_OP_W,
  parameter int ROB_W = iw_pkg::DEF_ROB_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  ins_valid,
  output logic                  ins_ready,
  output logic                  win_full,
  input  logic [OP_W-1:0]       ins_op,
  input  logic [NSRC*TAG_W-1:0] ins_src_tag,
  input  logic [NSRC-1:0]       ins_src_used,
  input  logic [NSRC-1:0]       ins_src_rdy,
  input  logic [TAG_W-1:0]      ins_dst_tag,
  input  logic [ROB_W-1:0]      ins_rob,
  input  logic [NWB-1:0]        wb_valid,
  input  logic [NWB*TAG_W-1:0]  wb_tag,
  output logic                  iss_valid,
  input  logic                  iss_ready,
  output logic [OP_W-1:0]       iss_op,
  output logic [NSRC*TAG_W-1:0] iss_src_tag,
  output logic [TAG_W-1:0]      iss_dst_tag,
  output logic [ROB_W-1:0]      iss_rob
);
  logic [DEPTH-1:0] occ, rdy, slot_oh, we, clr, grant;
  logic             full, fire;
  logic [OP_W-1:0]       e_op  [DEPTH];
  logic [NSRC*TAG_W-1:0] e_src [DEPTH];
  logic [TAG_W-1:0]      e_dst [DEPTH];
  logic [ROB_W-1:0]      e_rob [DEPTH];

  iw_alloc #(.DEPTH(DEPTH)) u_alloc (
    .occ(occ), .slot_oh(slot_oh), .full(full)
  );

  assign ins_ready = ~full;
  assign win_full  = full;
  assign we        = slot_oh & {DEPTH{ins_valid & ~full & ~flush}};
  assign iss_valid = (|grant) & ~flush;
  assign fire      = iss_valid & iss_ready;
  assign clr       = grant & {DEPTH{fire}};

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      iw_entry #(.NSRC(NSRC), .NWB(NWB), .TAG_W(TAG_W), .OP_W(OP_W), .ROB_W(ROB_W)) u_ent (
        .clk(clk), .rst_n(rst_n), .flush(flush), .we(we[i]), .clr(clr[i]),
        .in_op(ins_op), .in_src(ins_src_tag), .in_used(ins_src_used), .in_rdy(ins_src_rdy),
        .in_dst(ins_dst_tag), .in_rob(ins_rob),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .vld(occ[i]), .rdy(rdy[i]),
        .op(e_op[i]), .src(e_src[i]), .dst(e_dst[i]), .rob(e_rob[i])
      );
    end
  endgenerate

  iw_age #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ins_we(we), .rdy(rdy),
    .iss_ready(iss_ready), .grant(grant)
  );

  // one-hot payload mux
  always_comb begin
    iss_op      = '0;
    iss_src_tag = '0;
    iss_dst_tag = '0;
    iss_rob     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (grant[i]) begin
        iss_op      = iss_op      | e_op[i];
        iss_src_tag = iss_src_tag | e_src[i];
        iss_dst_tag = iss_dst_tag | e_dst[i];
        iss_rob     = iss_rob     | e_rob[i];
      end
    end
  end

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!iss_valid && !win_full));
  assert_stall_payload_stable_R9: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_rob) && $stable(iss_op)
                                   && $stable(iss_dst_tag) && $stable(iss_src_tag)));
  assert_full_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (win_full && !fire && !flush) |=> win_full);
endmodule

// File: tb/tb_iw_window.sv
`timescale 1ns/1ps
module tb_iw_window;
  localparam int DEPTH = 4, NSRC = 2, NWB = 2, TAG_W = 6, OP_W = 7, ROB_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic ins_valid = 1'b0, ins_ready, win_full;
  logic [OP_W-1:0] ins_op = '0;
  logic [NSRC*TAG_W-1:0] ins_src_tag = '0;
  logic [NSRC-1:0] ins_src_used = '0, ins_src_rdy = '0;
  logic [TAG_W-1:0] ins_dst_tag = '0;
  logic [ROB_W-1:0] ins_rob = '0;
  logic [NWB-1:0] wb_valid = '0;
  logic [NWB*TAG_W-1:0] wb_tag = '0;
  logic iss_valid, iss_ready = 1'b0;
  logic [OP_W-1:0] iss_op;
  logic [NSRC*TAG_W-1:0] iss_src_tag;
  logic [TAG_W-1:0] iss_dst_tag;
  logic [ROB_W-1:0] iss_rob;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  iw_window #(.DEPTH(DEPTH), .NSRC(NSRC), .NWB(NWB), .TAG_W(TAG_W), .OP_W(OP_W), .ROB_W(ROB_W)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .win_full(win_full),
    .ins_op(ins_op), .ins_src_tag(ins_src_tag), .ins_src_used(ins_src_used),
    .ins_src_rdy(ins_src_rdy), .ins_dst_tag(ins_dst_tag), .ins_rob(ins_rob),
    .wb_valid(wb_valid), .wb_tag(wb_tag),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_src_tag(iss_src_tag), .iss_dst_tag(iss_dst_tag), .iss_rob(iss_rob)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  // drive one insert beat (optionally with a broadcast on lane 0) for one cycle
  task automatic put(input int op, input int t0, input int t1, input int used, input int rdy,
                     input int dst, input int rob, input bit bc = 1'b0, input int bc_tag = 0);
    ins_valid    = 1'b1;
    ins_op       = OP_W'(op);
    ins_src_tag  = {TAG_W'(t1), TAG_W'(t0)};
    ins_src_used = NSRC'(used);
    ins_src_rdy  = NSRC'(rdy);
    ins_dst_tag  = TAG_W'(dst);
    ins_rob      = ROB_W'(rob);
    wb_valid     = {1'b0, bc};
    wb_tag       = {TAG_W'(0), TAG_W'(bc_tag)};
    @(negedge clk);
    ins_valid = 1'b0;
    wb_valid  = '0;
  endtask

  task automatic bcast(input bit v0, input int tag0, input bit v1, input int tag1);
    wb_valid = {v1, v0};
    wb_tag   = {TAG_W'(tag1), TAG_W'(tag0)};
    @(negedge clk);
    wb_valid = '0;
  endtask

  task automatic pop(input string req, input int rob);
    chk_eq(req, "iss_valid before accept", int'(iss_valid), 1);
    chk_eq(req, "iss_rob order", int'(iss_rob), rob);
    iss_ready = 1'b1;
    @(negedge clk);
    iss_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R1", "iss_valid after reset", int'(iss_valid), 0);
    chk_eq("R1", "win_full after reset", int'(win_full), 0);
    chk_eq("R1", "ins_ready after reset", int'(ins_ready), 1);
  endtask

  task automatic t_ready_insert();
    put(7'h11, 3, 4, 2'b11, 2'b11, 7, 2);
    chk_eq("R3", "ready insert offered next cycle", int'(iss_valid), 1);
    chk_eq("R8", "iss_op", int'(iss_op), 7'h11);
    chk_eq("R8", "iss_src_tag", int'(iss_src_tag), (4 << TAG_W) | 3);
    chk_eq("R8", "iss_dst_tag", int'(iss_dst_tag), 7);
    chk_eq("R8", "iss_rob", int'(iss_rob), 2);
    @(negedge clk);
    chk_eq("R9", "stalled beat still offered", int'(iss_valid), 1);
    chk_eq("R9", "stalled beat rob unchanged", int'(iss_rob), 2);
    pop("R9", 2);
    chk_eq("R9", "accepted slot released", int'(iss_valid), 0);
  endtask

  task automatic t_unused_src();
    put(7'h22, 1, 33, 2'b01, 2'b01, 8, 5);
    chk_eq("R3", "unused source counts as ready", int'(iss_valid), 1);
    pop("R3", 5);
  endtask

  task automatic t_wakeup();
    put(7'h05, 5, 9, 2'b11, 2'b00, 10, 4);
    chk_eq("R4", "waiting insert not offered", int'(iss_valid), 0);
    bcast(1'b1, 7, 1'b0, 9);
    chk_eq("R6", "mismatched or invalid broadcast ignored", int'(iss_valid), 0);
    bcast(1'b1, 5, 1'b0, 0);
    chk_eq("R4", "one source still waiting", int'(iss_valid), 0);
    bcast(1'b0, 0, 1'b1, 9);
    chk_eq("R4", "last source woken on lane 1", int'(iss_valid), 1);
    pop("R4", 4);
  endtask

  task automatic t_same_cycle();
    put(7'h33, 12, 13, 2'b11, 2'b10, 11, 6, 1'b1, 12);
    chk_eq("R5", "broadcast during insert applied", int'(iss_valid), 1);
    pop("R5", 6);
  endtask

  task automatic t_full_and_order();
    for (int k = 0; k < DEPTH; k++) put(k, 20 + k, 0, 2'b01, 2'b00, 40 + k, k);
    chk_eq("R2", "win_full with all slots held", int'(win_full), 1);
    chk_eq("R2", "ins_ready low when full", int'(ins_ready), 0);
    put(7'h7f, 1, 2, 2'b11, 2'b11, 50, 15);
    chk_eq("R2", "insert while full dropped", int'(iss_valid), 0);
    bcast(1'b1, 21, 1'b0, 0);
    pop("R4", 1);
    chk_eq("R2", "win_full clears after release", int'(win_full), 0);
    // younger ready instruction goes to slot 1 while slot 3 wakes
    put(7'h44, 2, 3, 2'b11, 2'b11, 51, 9, 1'b1, 23);
    chk_eq("R7", "older slot 3 chosen over younger slot 1", int'(iss_rob), 3);
    bcast(1'b1, 20, 1'b0, 0);
    chk_eq("R9", "stalled beat held when older wakes", int'(iss_rob), 3);
    pop("R9", 3);
    pop("R7", 0);
    pop("R7", 9);
    bcast(1'b0, 0, 1'b1, 22);
    pop("R7", 2);
    chk_eq("R2", "window drained, rob 15 never issued", int'(iss_valid), 0);
  endtask

  task automatic t_flush();
    put(1, 1, 1, 2'b11, 2'b11, 1, 5);
    put(2, 1, 1, 2'b11, 2'b11, 2, 6);
    ins_valid = 1'b1; ins_rob = 4'd7; ins_src_used = 2'b11; ins_src_rdy = 2'b11;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0; ins_valid = 1'b0;
    chk_eq("R10", "no beat after flush", int'(iss_valid), 0);
    chk_eq("R10", "not full after flush", int'(win_full), 0);
    @(negedge clk);
    chk_eq("R10", "insert during flush dropped", int'(iss_valid), 0);
    put(3, 1, 1, 2'b11, 2'b11, 3, 8);
    chk_eq("R10", "insert accepted after flush", int'(iss_valid), 1);
    pop("R10", 8);
  endtask

  // R11: never more than one beat; payload is single instruction (watched each cycle)
  always @(negedge clk) begin
    if (rst_n && iss_valid && $isunknown(iss_rob))
      check(1'b0, "R11", "unknown issue payload", 0, 1);
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ready_insert();
    t_unused_src();
    t_wakeup();
    t_same_cycle();
    t_full_and_order();
    t_flush();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule